// File: doc/BRIEF.md
# Unaligned Load Merge Unit

This unit serves a 64-bit load from any byte address while the memory behind it only ever supplies naturally aligned 64-bit words. A start pulse hands it a byte address. The unit clears the low three address bits to find the containing word and reads that word. If the address is not a multiple of eight, it also reads the following word. It then shifts the two words together, least significant byte first, so that byte 0 of the result is the byte at the requested address. The read port has variable latency. The unit keeps at most one read in flight and raises `rd_req` for exactly one cycle per read.

The result overwrites the register that held the lower word, and that register drives `result`. The upper word is kept, together with its aligned address. In streaming mode a caller can walk an array eight bytes at a time. When the aligned word under the new address is the retained upper word, the unit reuses it and issues only the one read it still needs.

The controller has six states. ST_IDLE waits for `start`. ST_REQ_LO issues the lower read and ST_WAIT_LO waits for its data. ST_REQ_HI issues the upper read and ST_WAIT_HI waits for its data. ST_DONE raises `done` for one cycle.

The transitions are:
- ST_IDLE goes to ST_REQ_LO on an ordinary start.
- ST_IDLE goes to ST_REQ_HI on a reusing start with a nonzero offset.
- ST_IDLE goes to ST_DONE on a reusing start with a zero offset.
- ST_REQ_LO goes to ST_WAIT_LO unconditionally.
- ST_WAIT_LO goes to ST_DONE on `rd_valid` when the offset is zero, and to ST_REQ_HI on `rd_valid` otherwise.
- ST_REQ_HI goes to ST_WAIT_HI unconditionally.
- ST_WAIT_HI goes to ST_DONE on `rd_valid`.
- ST_DONE goes back to ST_IDLE unconditionally.

Top module: `unaligned_load_unit`

## Requirements
- R1: Every read request carries an address whose low three bits are zero. For a start that does not reuse the retained word, the first read goes to the start address with its low three bits cleared.
- R2: When the byte offset (address bits 2:0) is nonzero, a second read goes to the first read's aligned address plus 8.
- R3: The result's byte i (bits 8i+7:8i) is the memory byte at start address plus i, for i = 0 to 7. Word data is little-endian: byte k of a word read at aligned address A is the byte at A+k.
- R4: With offset zero and no reuse, exactly one read is issued and the result is that word unchanged.
- R5: With `stream` high at start, if a retained upper word exists and its aligned address equals the start address with bits 2:0 cleared, the lower read is skipped. With offset zero, no read is issued at all.
- R6: At most one read is outstanding at a time. `rd_req` is high for one cycle per read, and the unit waits any number of cycles for `rd_valid`.
- R7: `done` is high for exactly one cycle per accepted start. `result` holds its value from that cycle until the next accepted start.
- R8: A `start` while `busy` is high is ignored. It issues no read and does not change the result.
- R9: A synchronous active-high `rst` returns the unit to idle with `busy`, `done`, `rd_req` and `result` at zero, and forgets the retained word.
- R10: Counting the rising edge that samples `start` as edge 0, and a read returning L edges after its request is sampled, `done` is high in the cycle after edge D. D is 2+2L for two reads, 1+L for one read, and 0 when no read is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load, accepted only when idle |
| stream | input | 1 | Allow reuse of the retained upper word |
| addr | input | ADDR_W | Byte address of the load |
| busy | output | 1 | High from accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Merged load value |
| rd_req | output | 1 | Read request, one cycle per read |
| rd_addr | output | ADDR_W | Aligned read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DATA_W | Read data word |

## Verification
Each start predicts a done edge from R10: 2+2L for a split load, 1+L for a single-read load, and 0 for a fully reused aligned load. The bench compares `done` on every falling edge from the start until that point, so a pulse that comes early, comes late or lasts two cycles is caught. The result and the logged read addresses are checked at the done cycle. Two idle cycles later the result is checked again to confirm it has not moved. The model memory returns each read exactly L falling edges after it sees the request, so the due cycle is fixed for each latency tried (1 to 4).

// File: rtl/ull_pkg.sv
package ull_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LO,
        ST_WAIT_LO,
        ST_REQ_HI,
        ST_WAIT_HI,
        ST_DONE
    } ull_state_e;
endpackage

// File: rtl/ull_addr_split.sv
module ull_addr_split #(
    parameter int ADDR_W = 32,
    parameter int BYTES  = 8,
    parameter int OFF_W  = $clog2(BYTES)
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [ADDR_W-1:0] word_base,
    output logic [ADDR_W-1:0] word_next,
    output logic [OFF_W-1:0]  byte_off
);
    assign byte_off  = byte_addr[OFF_W-1:0];
    assign word_base = {byte_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign word_next = word_base + ADDR_W'(BYTES);
endmodule

// File: rtl/ull_funnel.sv
module ull_funnel #(
    parameter int DATA_W = 64,
    parameter int BYTES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] low_word,
    input  logic [DATA_W-1:0] high_word,
    input  logic [OFF_W-1:0]  shift_bytes,
    output logic [DATA_W-1:0] merged
);
    logic [2*DATA_W-1:0] pair;
    assign pair = {high_word, low_word};

    // Each output byte picks the pair byte 'shift_bytes' positions above it;
    // offset zero selects the low word only, so no full-width shift exists.
    for (genvar gb = 0; gb < BYTES; gb++) begin : g_byte
        assign merged[gb*8 +: 8] = pair[(gb + int'(shift_bytes))*8 +: 8];
    end
endmodule

// File: rtl/unaligned_load_unit.sv
module unaligned_load_unit
    import ull_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stream,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);

    ull_state_e state_q, state_d;

    logic [OFF_W-1:0]  off_q;
    logic [ADDR_W-1:0] base_q, next_q;
    logic [DATA_W-1:0] lo_q, hi_q;
    logic [ADDR_W-1:0] hi_tag_q;
    logic              hi_valid_q;

    logic [ADDR_W-1:0] in_base, in_next;
    logic [OFF_W-1:0]  in_off;
    logic [DATA_W-1:0] merged;
    logic              accept, reuse;

    ull_addr_split #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_split (
        .byte_addr (addr),
        .word_base (in_base),
        .word_next (in_next),
        .byte_off  (in_off)
    );

    ull_funnel #(.DATA_W(DATA_W)) u_funnel (
        .low_word    (lo_q),
        .high_word   (rd_data),
        .shift_bytes (off_q),
        .merged      (merged)
    );

    assign accept = start && (state_q == ST_IDLE);
    assign reuse  = stream && hi_valid_q && (in_base == hi_tag_q);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!reuse)             state_d = ST_REQ_LO;
                    else if (in_off == '0)  state_d = ST_DONE;
                    else                    state_d = ST_REQ_HI;
                end
            end
            ST_REQ_LO:  state_d = ST_WAIT_LO;
            ST_WAIT_LO: if (rd_valid) state_d = (off_q == '0) ? ST_DONE : ST_REQ_HI;
            ST_REQ_HI:  state_d = ST_WAIT_HI;
            ST_WAIT_HI: if (rd_valid) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Word registers: lo_q becomes the result, hi_q is kept for streaming
    always_ff @(posedge clk) begin
        if (rst) begin
            off_q      <= '0;
            base_q     <= '0;
            next_q     <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            hi_tag_q   <= '0;
            hi_valid_q <= 1'b0;
        end else begin
            if (accept) begin
                off_q  <= in_off;
                base_q <= in_base;
                next_q <= in_next;
                if (reuse) lo_q <= hi_q;
            end
            if (state_q == ST_WAIT_LO && rd_valid) lo_q <= rd_data;
            if (state_q == ST_WAIT_HI && rd_valid) begin
                lo_q       <= merged;
                hi_q       <= rd_data;
                hi_tag_q   <= next_q;
                hi_valid_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        rd_req  = (state_q == ST_REQ_LO) || (state_q == ST_REQ_HI);
        rd_addr = (state_q == ST_REQ_HI) ? next_q : base_q;
        result  = lo_q;
    end

    a_r1_read_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr[OFF_W-1:0] == '0));

    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(result));

    a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

// File: tb/unaligned_load_unit_tb.sv
module unaligned_load_unit_tb;
    logic        clk = 1'b0;
    logic        rst, start, stream;
    logic [31:0] addr;
    logic        busy, done, rd_req, rd_valid;
    logic [63:0] result, rd_data;
    logic [31:0] rd_addr;

    int total = 0;
    int bad   = 0;
    int mem_lat = 1;
    int pend = 0;
    logic [31:0] paddr;
    logic [31:0] req_log [8];
    int req_n = 0;

    always #2 clk = ~clk;

    unaligned_load_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .stream(stream), .addr(addr),
        .busy(busy), .done(done), .result(result),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [63:0] span(input logic [31:0] a);
        logic [63:0] w;
        for (int i = 0; i < 8; i++) w[i*8 +: 8] = mbyte(a + 32'(i));
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: answers each request exactly mem_lat falling edges later
    initial begin
        rd_valid = 1'b0;
        rd_data  = '0;
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = span(paddr);
                end
            end
            if (rd_req) begin
                if (req_n < 8) req_log[req_n] = rd_addr;
                req_n++;
                paddr = rd_addr;
                pend  = mem_lat;
            end
        end
    end

    task automatic run_op(input logic [31:0] a, input bit strm, input int lat,
                          input int expd, input int nreq,
                          input logic [31:0] r0, input logic [31:0] r1,
                          input bit poke, input string req);
        logic [63:0] exp_v, held;
        mem_lat = lat;
        req_n = 0;
        exp_v = span(a);
        @(negedge clk);
        start = 1'b1; stream = strm; addr = a;
        for (int k = 1; k <= expd + 1; k++) begin
            @(negedge clk);
            if (poke && k == 2) begin
                start = 1'b1; addr = a + 32'h400;
            end else begin
                start = 1'b0;
            end
            chk(done == (k == expd + 1), "R10", $sformatf("done at step %0d", k),
                64'(done), 64'(k == expd + 1));
        end
        start = 1'b0;
        chk(result == exp_v, req, "merged result", result, exp_v);
        chk(req_n == nreq, "R6", "read count", 64'(req_n), 64'(nreq));
        if (nreq > 0) chk(req_log[0] == r0, "R1", "first read addr", 64'(req_log[0]), 64'(r0));
        if (nreq > 1) chk(req_log[1] == r1, "R2", "second read addr", 64'(req_log[1]), 64'(r1));
        held = result;
        @(negedge clk);
        @(negedge clk);
        chk(result == held && !done && !busy, "R7", "result held after done",
            result, held);
        if (poke) chk(req_n == nreq, "R8", "no read from ignored start",
                      64'(req_n), 64'(nreq));
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; stream = 1'b0; addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !rd_req && result == '0, "R9", "reset state",
            result, 64'd0);

        run_op(32'h100, 0, 1, 2, 1, 32'h100, 0, 0, "R4");
        run_op(32'h103, 0, 1, 4, 2, 32'h100, 32'h108, 0, "R3");
        run_op(32'h10F, 0, 3, 8, 2, 32'h108, 32'h110, 1, "R3");
        run_op(32'h115, 1, 2, 3, 1, 32'h118, 0, 0, "R5");
        run_op(32'h11D, 1, 2, 3, 1, 32'h120, 0, 1, "R5");
        run_op(32'h120, 1, 1, 0, 0, 0, 0, 0, "R5");
        run_op(32'h127, 1, 1, 2, 1, 32'h128, 0, 0, "R5");
        run_op(32'h205, 1, 1, 4, 2, 32'h200, 32'h208, 0, "R3");
        run_op(32'h307, 0, 4, 10, 2, 32'h300, 32'h308, 0, "R3");
        run_op(32'h309, 0, 2, 6, 2, 32'h308, 32'h310, 0, "R2");

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && result == '0, "R9", "state after second reset",
            result, 64'd0);
        // Retained word at 0x310 must be forgotten: both reads happen again
        run_op(32'h30A, 1, 1, 4, 2, 32'h308, 32'h310, 0, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule